// File: doc/BRIEF.md
# Fuzzy Min-Max Rule Engine with Singleton Defuzzifier

This block sits after a fuzzification stage in a fuzzy temperature controller. It receives seven membership degrees in one word. Four degrees grade the temperature error and three grade its rate of change. Each of the twelve error/rate pairings is one rule. A rule fires with the smaller of its two degrees, and a parameter table routes it to one of three output classes: slow, moderate or fast. Each class keeps the strongest rule that routes to it.

The three class strengths weight three constant 12-bit singleton levels. The crisp output is the sum of the strength-times-level products divided by the sum of the strengths. A restoring divider forms that quotient one bit per clock.

A producer presents a request with `in_valid` whenever `busy` is low. The block takes it on that clock edge. The result comes back on `out_val` together with a one-cycle `out_valid` pulse. Requests made while `busy` is high are dropped.

Top module: `fuzzy_minmax_defuzz`

## Requirements
- R1: After reset, `busy` and `out_valid` are low and `out_val` is zero.
- R2: The strength of the rule for error term e (0..3) and rate term r (0..2) is the minimum of the two degrees. Rule e*3+r reads its class code from bits [2(e*3+r)+1 : 2(e*3+r)] of the rule table. Code 0 is slow, 1 is moderate, 2 is fast and 3 leaves the rule unused. The default table gives class min((e+r)/2, 2).
- R3: Each class strength is the maximum over the rules routed to that class, not their sum.
- R4: For a non-zero strength sum, `out_val` equals floor(Σ strength×level / Σ strength), saturated to 4095. The default levels are 512 (slow), 2048 (moderate) and 3840 (fast). The result never exceeds the largest level.
- R5: When all three class strengths are zero, no division starts. `out_val` becomes 0 and `out_valid` is raised at the accepting edge itself.
- R6: For a non-zero strength sum, `busy` rises at the accepting edge. `out_valid` rises NUM_W+1 clock edges after it, where NUM_W = DEG_W+OUT_W+2 (29 edges with the default widths).
- R7: A request made while `busy` is high is ignored. It does not change the pending result and produces no extra `out_valid` pulse.
- R8: `out_valid` lasts exactly one cycle. `out_val` holds its value until the next pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request; taken on a rising edge while `busy` is low |
| err_deg | input | 4*DEG_W | Error degrees; term e at bits [e*DEG_W +: DEG_W] |
| rate_deg | input | 3*DEG_W | Rate degrees; term r at bits [r*DEG_W +: DEG_W] |
| busy | output | 1 | High while a request is in flight or its result is being shown |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_val | output | OUT_W | Crisp output level |

## Verification
The hardest effect to see from the ports is the max aggregation. When only one rule per class fires, max and sum give the same result. The stimulus therefore includes hand-built cases in which several rules of the same class fire with equal and with different strengths, so that a summing design would visibly change the quotient. A sweep of generated degree sets adds three more patterns: sparse patterns like those from a fuzzifier, dense random patterns, and tiny values that often make every strength zero. Requests are also held high through the divider run and through the one-cycle result window, to show they are dropped.

// File: rtl/fz_pkg.sv
package fz_pkg;
    localparam int ERR_TERMS  = 4;
    localparam int RATE_TERMS = 3;
    localparam int N_RULES    = ERR_TERMS * RATE_TERMS;
    localparam int N_CLASS    = 3;
    localparam int CLS_W      = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_SLOW = 2'd0,
        CLS_MOD  = 2'd1,
        CLS_FAST = 2'd2,
        CLS_NONE = 2'd3
    } out_class_e;
endpackage

// File: rtl/fz_rule_eval.sv
module fz_rule_eval
    import fz_pkg::*;
#(
    parameter int                       DEG_W    = 14,
    parameter logic [2*N_RULES-1:0]     RULE_MAP = 24'hA65510
) (
    input  logic [ERR_TERMS*DEG_W-1:0]  err_deg,
    input  logic [RATE_TERMS*DEG_W-1:0] rate_deg,
    output logic [N_CLASS*DEG_W-1:0]    cls_str
);
    logic [DEG_W-1:0] rule_str [N_RULES];
    logic [CLS_W-1:0] rule_cls [N_RULES];
    logic [DEG_W-1:0] agg      [N_CLASS];

    for (genvar e = 0; e < ERR_TERMS; e++) begin : g_err
        for (genvar r = 0; r < RATE_TERMS; r++) begin : g_rate
            localparam int IDX = e * RATE_TERMS + r;
            logic [DEG_W-1:0] a_deg, b_deg;
            assign a_deg         = err_deg[e*DEG_W +: DEG_W];
            assign b_deg         = rate_deg[r*DEG_W +: DEG_W];
            assign rule_str[IDX] = (a_deg < b_deg) ? a_deg : b_deg;
            assign rule_cls[IDX] = RULE_MAP[2*IDX +: 2];
        end
    end

    always_comb begin
        for (int c = 0; c < N_CLASS; c++) begin
            agg[c] = '0;
            for (int i = 0; i < N_RULES; i++) begin
                if (rule_cls[i] == c[CLS_W-1:0] && rule_str[i] > agg[c]) begin
                    agg[c] = rule_str[i];
                end
            end
        end
    end

    for (genvar c = 0; c < N_CLASS; c++) begin : g_out
        assign cls_str[c*DEG_W +: DEG_W] = agg[c];
    end
endmodule

// File: rtl/fz_wavg_sum.sv
module fz_wavg_sum
    import fz_pkg::*;
#(
    parameter int               DEG_W     = 14,
    parameter int               OUT_W     = 12,
    parameter logic [OUT_W-1:0] SING_SLOW = 12'd512,
    parameter logic [OUT_W-1:0] SING_MOD  = 12'd2048,
    parameter logic [OUT_W-1:0] SING_FAST = 12'd3840,
    localparam int              NUM_W     = DEG_W + OUT_W + 2,
    localparam int              DEN_W     = DEG_W + 2
) (
    input  logic [N_CLASS*DEG_W-1:0] cls_str,
    output logic [NUM_W-1:0]         num,
    output logic [DEN_W-1:0]         den
);
    localparam logic [N_CLASS*OUT_W-1:0] SING_PK = {SING_FAST, SING_MOD, SING_SLOW};

    logic [NUM_W-1:0] prod [N_CLASS];
    logic [DEN_W-1:0] wide [N_CLASS];

    for (genvar c = 0; c < N_CLASS; c++) begin : g_mac
        assign wide[c] = DEN_W'(cls_str[c*DEG_W +: DEG_W]);
        assign prod[c] = NUM_W'(cls_str[c*DEG_W +: DEG_W]) * NUM_W'(SING_PK[c*OUT_W +: OUT_W]);
    end

    always_comb begin
        num = '0;
        den = '0;
        for (int c = 0; c < N_CLASS; c++) begin
            num = num + prod[c];
            den = den + wide[c];
        end
    end
endmodule

// File: rtl/fz_seq_div.sv
module fz_seq_div #(
    parameter int  NUM_W = 28,
    parameter int  DEN_W = 16,
    localparam int CNT_W = $clog2(NUM_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] dsr;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
    } div_st_t;

    div_st_t      st_d, st_q;
    logic [DEN_W:0] part;
    logic           qbit;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        part      = '0;
        qbit      = 1'b0;
        if (st_q.busy) begin
            part = {st_q.rem, st_q.quo[NUM_W-1]};
            if (part >= {1'b0, st_q.dsr}) begin
                part = part - {1'b0, st_q.dsr};
                qbit = 1'b1;
            end
            st_d.rem = part[DEN_W-1:0];
            st_d.quo = {st_q.quo[NUM_W-2:0], qbit};
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(NUM_W - 1);
            st_d.dsr  = den;
            st_d.rem  = '0;
            st_d.quo  = num;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
    assign quo  = st_q.quo;
endmodule

// File: rtl/fuzzy_minmax_defuzz.sv
module fuzzy_minmax_defuzz
    import fz_pkg::*;
#(
    parameter int                   DEG_W     = 14,
    parameter int                   OUT_W     = 12,
    parameter logic [OUT_W-1:0]     SING_SLOW = 12'd512,
    parameter logic [OUT_W-1:0]     SING_MOD  = 12'd2048,
    parameter logic [OUT_W-1:0]     SING_FAST = 12'd3840,
    parameter logic [2*N_RULES-1:0] RULE_MAP  = 24'hA65510
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [ERR_TERMS*DEG_W-1:0]  err_deg,
    input  logic [RATE_TERMS*DEG_W-1:0] rate_deg,
    output logic                        busy,
    output logic                        out_valid,
    output logic [OUT_W-1:0]            out_val
);
    localparam int NUM_W = DEG_W + OUT_W + 2;
    localparam int DEN_W = DEG_W + 2;

    typedef struct packed {
        logic             out_valid;
        logic [OUT_W-1:0] out_val;
    } top_st_t;

    top_st_t                  st_d, st_q;
    logic [N_CLASS*DEG_W-1:0] cls_str;
    logic [NUM_W-1:0]         num_sum;
    logic [DEN_W-1:0]         den_sum;
    logic                     accept, den_zero, div_start;
    logic                     div_busy, div_done;
    logic [NUM_W-1:0]         div_quo;
    logic [OUT_W-1:0]         quo_sat;

    fz_rule_eval #(.DEG_W(DEG_W), .RULE_MAP(RULE_MAP)) i_rules (
        .err_deg (err_deg),
        .rate_deg(rate_deg),
        .cls_str (cls_str)
    );

    fz_wavg_sum #(
        .DEG_W(DEG_W), .OUT_W(OUT_W),
        .SING_SLOW(SING_SLOW), .SING_MOD(SING_MOD), .SING_FAST(SING_FAST)
    ) i_sum (
        .cls_str(cls_str),
        .num    (num_sum),
        .den    (den_sum)
    );

    fz_seq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) i_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(div_start),
        .num  (num_sum),
        .den  (den_sum),
        .busy (div_busy),
        .done (div_done),
        .quo  (div_quo)
    );

    assign busy      = div_busy | div_done | st_q.out_valid;
    assign accept    = in_valid & ~busy;
    assign den_zero  = (den_sum == '0);
    assign div_start = accept & ~den_zero;
    assign quo_sat   = (|div_quo[NUM_W-1:OUT_W]) ? {OUT_W{1'b1}} : div_quo[OUT_W-1:0];

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        if (accept && den_zero) begin
            st_d.out_valid = 1'b1;
            st_d.out_val   = '0;
        end else if (div_done) begin
            st_d.out_valid = 1'b1;
            st_d.out_val   = quo_sat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_valid;
    assign out_val   = st_q.out_val;
endmodule

// File: rtl/fz_defuzz_chk.sv
module fz_defuzz_chk #(
    parameter int               OUT_W     = 12,
    parameter int               DEN_W     = 16,
    parameter logic [OUT_W-1:0] SING_SLOW = 12'd512,
    parameter logic [OUT_W-1:0] SING_MOD  = 12'd2048,
    parameter logic [OUT_W-1:0] SING_FAST = 12'd3840
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             busy,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_val,
    input logic [DEN_W-1:0] den_sum
);
    localparam logic [OUT_W-1:0] MAX_A = (SING_SLOW > SING_MOD) ? SING_SLOW : SING_MOD;
    localparam logic [OUT_W-1:0] MAX_S = (MAX_A > SING_FAST) ? MAX_A : SING_FAST;

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_val));

    // R4
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_val <= MAX_S);

    // R5
    zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy && den_sum == '0) |=> (out_valid && out_val == '0));

    // R6
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy && den_sum != '0) |=> (busy && !out_valid));
endmodule

bind fuzzy_minmax_defuzz fz_defuzz_chk #(
    .OUT_W(OUT_W), .DEN_W(DEG_W + 2),
    .SING_SLOW(SING_SLOW), .SING_MOD(SING_MOD), .SING_FAST(SING_FAST)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .busy     (busy),
    .out_valid(out_valid),
    .out_val  (out_val),
    .den_sum  (den_sum)
);

// File: tb/test_fuzzy_minmax_defuzz.sv
module test_fuzzy_minmax_defuzz;
    localparam int DEG_W = 14;
    localparam int OUT_W = 12;
    localparam int NUM_W = DEG_W + OUT_W + 2;
    localparam longint DMAX = (1 << DEG_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [4*DEG_W-1:0] err_deg = '0;
    logic [3*DEG_W-1:0] rate_deg = '0;
    logic               busy, out_valid;
    logic [OUT_W-1:0]   out_val;

    int     n_chk = 0;
    int     n_err = 0;
    int     cyc = 0;
    longint ev [4];
    longint rv [3];

    always #4 clk = ~clk;

    fuzzy_minmax_defuzz i_fuzzy_minmax_defuzz (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .err_deg(err_deg), .rate_deg(rate_deg),
        .busy(busy), .out_valid(out_valid), .out_val(out_val)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint ref_den();
        longint s [3];
        for (int c = 0; c < 3; c++) s[c] = 0;
        for (int e = 0; e < 4; e++) begin
            for (int r = 0; r < 3; r++) begin
                longint m = (ev[e] < rv[r]) ? ev[e] : rv[r];
                int c = (e + r) / 2;
                if (c > 2) c = 2;
                if (m > s[c]) s[c] = m;
            end
        end
        return s[0] + s[1] + s[2];
    endfunction

    function automatic longint ref_out();
        longint s [3];
        longint num, den, q;
        for (int c = 0; c < 3; c++) s[c] = 0;
        for (int e = 0; e < 4; e++) begin
            for (int r = 0; r < 3; r++) begin
                longint m = (ev[e] < rv[r]) ? ev[e] : rv[r];
                int c = (e + r) / 2;
                if (c > 2) c = 2;
                if (m > s[c]) s[c] = m;
            end
        end
        den = s[0] + s[1] + s[2];
        if (den == 0) return 0;
        num = s[0] * 512 + s[1] * 2048 + s[2] * 3840;
        q = num / den;
        if (q > 4095) q = 4095;
        return q;
    endfunction

    task automatic pack_in();
        for (int e = 0; e < 4; e++) err_deg[e*DEG_W +: DEG_W] = ev[e][DEG_W-1:0];
        for (int r = 0; r < 3; r++) rate_deg[r*DEG_W +: DEG_W] = rv[r][DEG_W-1:0];
    endtask

    task automatic set_in(input longint e0, e1, e2, e3, r0, r1, r2);
        ev[0] = e0; ev[1] = e1; ev[2] = e2; ev[3] = e3;
        rv[0] = r0; rv[1] = r1; rv[2] = r2;
    endtask

    // Runs one request; hold_cycles > 0 keeps in_valid high with other data afterwards.
    task automatic run_txn(input string req, input int hold_cycles);
        longint exp_v = ref_out();
        longint exp_lat = (ref_den() == 0) ? 1 : NUM_W + 2;
        int cnt;
        logic [OUT_W-1:0] seen;
        while (busy) @(negedge clk);
        pack_in();
        in_valid = 1'b1;
        @(negedge clk);
        cnt = 1;
        if (hold_cycles > 0) begin
            err_deg = {4{14'h1ABC}};
            rate_deg = {3{14'h2DEF}};
        end else begin
            in_valid = 1'b0;
        end
        if (exp_lat != 1) chk("R6 busy after accept", busy, 1);
        while (!out_valid && cnt < 200) begin
            if (hold_cycles > 0 && cnt >= hold_cycles) in_valid = 1'b0;
            @(negedge clk);
            cnt++;
        end
        chk({req, " value"}, out_val, exp_v);
        chk("R6 latency", cnt, exp_lat);
        seen = out_val;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 pulse width", out_valid, 0);
        chk("R8 hold", out_val, seen);
        if (hold_cycles > 0) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk("R7 no extra result", out_valid, 0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 out_val", out_val, 0);

        // R5 all-zero and disjoint-zero strengths
        set_in(0, 0, 0, 0, 0, 0, 0);
        run_txn("R5 all zero", 0);
        set_in(DMAX, DMAX, DMAX, DMAX, 0, 0, 0);
        run_txn("R5 rate zero", 0);

        // R2 single rule drives the output to its class level
        for (int e = 0; e < 4; e++) begin
            for (int r = 0; r < 3; r++) begin
                for (int c = 0; c < 4; c++) ev[c] = 0;
                for (int c = 0; c < 3; c++) rv[c] = 0;
                ev[e] = 3000 + e * 100;
                rv[r] = 7000;
                run_txn("R2 single rule", 0);
            end
        end

        // R3 several slow rules firing; a sum would give 1472
        set_in(1000, 6000, 0, 0, 1000, 5000, 0);
        run_txn("R3 max not sum", 0);
        chk("R3 fixed case", out_val, 1792);
        set_in(200, 9000, 0, 0, 8000, 300, 0);
        run_txn("R3 unequal strengths", 0);

        // R4 full-scale degrees
        set_in(DMAX, DMAX, DMAX, DMAX, DMAX, DMAX, DMAX);
        run_txn("R4 full scale", 0);
        set_in(0, 0, 0, DMAX, 0, 0, DMAX);
        run_txn("R4 fast only", 0);
        chk("R4 fast level", out_val, 3840);

        // R7 requests held during a division and during the result cycle
        set_in(5000, 2000, 0, 0, 4000, 100, 0);
        run_txn("R7 held during divide", 6);
        set_in(0, 0, 0, 0, 0, 0, 0);
        run_txn("R7 held during result", 1);

        // R4 sweep over generated patterns
        for (int i = 0; i < 1500; i++) begin
            int sel = i % 4;
            for (int e = 0; e < 4; e++) ev[e] = longint'($urandom) & DMAX;
            for (int r = 0; r < 3; r++) rv[r] = longint'($urandom) & DMAX;
            if (sel == 1) begin
                int ke = $urandom % 3;
                int kr = $urandom % 2;
                for (int e = 0; e < 4; e++) if (e != ke && e != ke + 1) ev[e] = 0;
                for (int r = 0; r < 3; r++) if (r != kr && r != kr + 1) rv[r] = 0;
            end else if (sel == 2) begin
                for (int e = 0; e < 4; e++) if ($urandom % 2 == 0) ev[e] = 0;
                for (int r = 0; r < 3; r++) if ($urandom % 2 == 0) rv[r] = 0;
            end else if (sel == 3) begin
                for (int e = 0; e < 4; e++) ev[e] = ev[e] & 3;
                for (int r = 0; r < 3; r++) rv[r] = (rv[r] & 1) * (longint'($urandom) & 1);
            end
            run_txn("R4 sweep", 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule